// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block is one DMA channel. Software writes a descriptor into four configuration registers, then arms the channel through a separate arm/abort port. Once armed, the channel waits for a start event. The start event is either a manual request pulse or a pulse on one hardware trigger line, picked by the descriptor's trigger select field. On a start, the channel copies units (bytes or 16-bit words) from a source pointer to a destination pointer. It uses a simple memory port with a one-cycle read latency.

The unit count can come from a fixed length field. It can also come from the value of the first unit moved, under one of four offset rules. Either pointer can stay still, step forward by one or two units, or step back by one unit after each unit. In single-unit modes each start moves one unit. In block modes each start moves the whole block. The repeated variants reload the pointers and count after completion and stay armed. When interrupts are enabled in the descriptor, a completed transfer raises a one-cycle done pulse. An abort stops the channel at the next unit boundary and gives no done pulse.

Top module: `dmach_top`

## Requirements
- R1: While and after a synchronous reset, `armed`, `mem_rd_req`, `mem_wr_req` and `irq_done` are 0.
- R2: Writing `cfg_sel` 0 sets the source base and `cfg_sel` 1 sets the destination base. `cfg_sel` 2 takes the length in bits 12:0 and the length mode in bits 15:13. `cfg_sel` 3 takes the control word: bit 0 word size, bits 2:1 transfer mode, bits 7:3 trigger select, bits 9:8 source step, bits 11:10 destination step, bit 12 interrupt enable, bit 13 seven-bit count.
- R3: An arm write with bit 0 set and bit 7 clear arms an idle channel and loads the pointers and count from the descriptor. With bits 7 and 0 both set, the write aborts the channel, and an idle channel is disarmed at once. With bit 0 clear, the write has no effect.
- R4: A transfer starts only when the channel is armed and idle. `man_req` starts it for any trigger select. `trig_in[n]` starts it when the trigger select equals n and n is not 0, so n = 1 is the chain input from a preceding channel. With select 0, every `trig_in` line is ignored.
- R5: Each unit is a read of the source pointer, issued one cycle after the start. The read data is taken one cycle after the read. A write of that data to the destination pointer follows one cycle later. Read and write are never requested in the same cycle.
- R6: Length mode 0 moves LEN units. LEN 0 completes on the start with no bus request.
- R7: Let V be the count value of the first unit. Length modes 1, 3 and 4 move 1+V, 2+V and 3+V units. Mode 2 moves V units counting the first, and at least the first unit.
- R8: The count value is the low 8 bits of the first unit when the seven-bit option is 0, and its low 7 bits when the option is 1.
- R9: Word size 0 moves bytes and drives `mem_wdata[15:8]` as 0. Word size 1 moves 16-bit words with `mem_word` high.
- R10: Step codes 0, 1, 2 and 3 change a pointer by 0, +1 unit, +2 units and -1 unit after each unit. A unit is 1 byte address for bytes and 2 for words.
- R11: Transfer modes 0 and 2 move one unit per start. Modes 1 and 3 move all remaining units per start.
- R12: On completion in modes 2 and 3, the channel stays armed and reloads its pointers and count, so the next start repeats the same transfer. In modes 0 and 1 it disarms.
- R13: An abort during a transfer lets the current unit finish, then stops the channel. The channel disarms and gives no done pulse.
- R14: On completion, `irq_done` pulses for one cycle if interrupts are enabled, and stays 0 if they are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor register write strobe |
| cfg_sel | input | 2 | Descriptor register select |
| cfg_wdata | input | 16 | Descriptor write data |
| arm_we | input | 1 | Arm/abort register write strobe |
| arm_wdata | input | 8 | Arm/abort data (bit 0 channel, bit 7 abort) |
| man_req | input | 1 | Manual start request |
| trig_in | input | NTRIG | Hardware trigger pulses, indexed by trigger select |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_word | output | 1 | Access is a 16-bit word |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| armed | output | 1 | Channel armed flag |
| irq_done | output | 1 | Done interrupt pulse |

## Verification
The copy path is tried with fixed-length blocks, with single-unit transfers started by the correct hardware line, a wrong line and the manual request, and with all four variable-length rules from one first value. Comparing the unit counts of these runs separates the offset rules from one another and from the fixed length. A first value of 0x83 with the seven-bit option on and off tells 4 units from 132 units, so the count mask is confirmed. Word transfers, and byte transfers with a +2 source step against a -1 destination step, show the unit scaling and each step code by the addresses written. Repeated-mode runs with changed source data show that the pointers are reloaded. A zero length, an idle abort and a mid-block abort confirm the completion paths that move no data or give no interrupt.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int LEN_W  = 13;
  localparam int TSEL_W = 5;

  localparam logic [2:0] LM_FIXED   = 3'd0;
  localparam logic [2:0] LM_ONEPLUS = 3'd1;
  localparam logic [2:0] LM_INCL    = 3'd2;
  localparam logic [2:0] LM_PLUS1   = 3'd3;
  localparam logic [2:0] LM_PLUS2   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CAP, ST_WR} chan_state_e;

  typedef struct packed {
    logic              cnt7;
    logic              irq_en;
    logic [1:0]        dst_step;
    logic [1:0]        src_step;
    logic [TSEL_W-1:0] tsel;
    logic [1:0]        tmode;
    logic              wsize;
  } chan_ctl_t;
endpackage

// File: rtl/dmach_desc_regs.sv
module dmach_desc_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [15:0]       wdata,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [LEN_W-1:0]  len,
  output logic [2:0]        lmode,
  output chan_ctl_t         ctl
);
  localparam int CTL_W = $bits(chan_ctl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base <= '0;
      dst_base <= '0;
      len      <= '0;
      lmode    <= '0;
      ctl      <= '0;
    end else if (we) begin
      case (sel)
        2'd0: src_base <= ADDR_W'(wdata);
        2'd1: dst_base <= ADDR_W'(wdata);
        2'd2: begin
          len   <= wdata[LEN_W-1:0];
          lmode <= wdata[15:13];
        end
        default: ctl <= chan_ctl_t'(wdata[CTL_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/dmach_trig_sel.sv
module dmach_trig_sel
  import dmach_pkg::*;
#(
  parameter int NTRIG = 32
) (
  input  logic [NTRIG-1:0]  trig_in,
  input  logic [TSEL_W-1:0] tsel,
  output logic              hit
);
  logic [NTRIG-1:0] match;

  for (genvar i = 0; i < NTRIG; i++) begin : g_line
    assign match[i] = trig_in[i] && (tsel == TSEL_W'(i));
  end

  assign hit = (|match) && (tsel != '0);
endmodule

// File: rtl/dmach_ptr_step.sv
module dmach_ptr_step #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  input  logic [1:0]        code,
  input  logic              wsize,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] unit;
  logic [ADDR_W-1:0] delta;

  assign unit = wsize ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    case (code)
      2'd0:    delta = '0;
      2'd1:    delta = unit;
      2'd2:    delta = unit << 1;
      default: delta = ADDR_W'(0) - unit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= base;
    else if (step) ptr <= ptr + delta;
  end

  // R10: the pointer holds its value between loads and steps
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(ptr));
endmodule

// File: rtl/dmach_len_calc.sv
module dmach_len_calc
  import dmach_pkg::*;
(
  input  logic [7:0]       first,
  input  logic             cnt7,
  input  logic [2:0]       lmode,
  output logic [LEN_W-1:0] rest
);
  logic [7:0]       v;
  logic [LEN_W-1:0] vx;

  assign v  = cnt7 ? {1'b0, first[6:0]} : first;
  assign vx = LEN_W'(v);

  always_comb begin
    case (lmode)
      LM_INCL:  rest = (v == 8'd0) ? '0 : vx - LEN_W'(1);
      LM_PLUS1: rest = vx + LEN_W'(1);
      LM_PLUS2: rest = vx + LEN_W'(2);
      default:  rest = vx;
    endcase
  end
endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NTRIG  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              arm_we,
  input  logic [7:0]        arm_wdata,
  input  logic              man_req,
  input  logic [NTRIG-1:0]  trig_in,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              armed,
  output logic              irq_done
);
  logic [ADDR_W-1:0] src_base, dst_base, src_ptr, dst_ptr;
  logic [LEN_W-1:0]  len, rem, rem_next, first_rest;
  logic [2:0]        lmode;
  chan_ctl_t         ctl;
  chan_state_e       st;
  logic              trig_hit, first_q, abort_pend;
  logic              var_mode, rep_mode, blk_mode;
  logic              arm_go, abort_wr, abort_now, start, zero_done, wr_done, reload;

  dmach_desc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .src_base(src_base), .dst_base(dst_base), .len(len), .lmode(lmode), .ctl(ctl)
  );

  dmach_trig_sel #(.NTRIG(NTRIG)) u_trig (
    .trig_in(trig_in), .tsel(ctl.tsel), .hit(trig_hit)
  );

  dmach_ptr_step #(.ADDR_W(ADDR_W)) u_src (
    .clk(clk), .rst(rst), .load(reload), .base(src_base),
    .step(st == ST_RD), .code(ctl.src_step), .wsize(ctl.wsize), .ptr(src_ptr)
  );

  dmach_ptr_step #(.ADDR_W(ADDR_W)) u_dst (
    .clk(clk), .rst(rst), .load(reload), .base(dst_base),
    .step(st == ST_WR), .code(ctl.dst_step), .wsize(ctl.wsize), .ptr(dst_ptr)
  );

  dmach_len_calc u_len (
    .first(mem_wdata[7:0]), .cnt7(ctl.cnt7), .lmode(lmode), .rest(first_rest)
  );

  assign var_mode  = (lmode >= LM_ONEPLUS) && (lmode <= LM_PLUS2);
  assign rep_mode  = ctl.tmode[1];
  assign blk_mode  = ctl.tmode[0];
  assign abort_wr  = arm_we && arm_wdata[0] && arm_wdata[7];
  assign arm_go    = (st == ST_IDLE) && arm_we && arm_wdata[0] && !arm_wdata[7];
  assign start     = (st == ST_IDLE) && armed && !arm_we && (man_req || trig_hit);
  assign zero_done = start && !var_mode && (rem == '0);
  assign abort_now = abort_pend || abort_wr;
  assign rem_next  = (first_q && var_mode) ? first_rest : rem - LEN_W'(1);
  assign wr_done   = (st == ST_WR) && !abort_now && (rem_next == '0);
  assign reload    = arm_go || ((zero_done || wr_done) && rep_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      armed      <= 1'b0;
      mem_rd_req <= 1'b0;
      mem_wr_req <= 1'b0;
      mem_word   <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      irq_done   <= 1'b0;
      rem        <= '0;
      first_q    <= 1'b0;
      abort_pend <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          abort_pend <= 1'b0;
          if (abort_wr) begin
            armed <= 1'b0;
          end else if (arm_go) begin
            armed   <= 1'b1;
            rem     <= len;
            first_q <= 1'b1;
          end else if (zero_done) begin
            irq_done <= ctl.irq_en;
            if (rep_mode) begin
              rem     <= len;
              first_q <= 1'b1;
            end else begin
              armed <= 1'b0;
            end
          end else if (start) begin
            st         <= ST_RD;
            mem_rd_req <= 1'b1;
            mem_word   <= ctl.wsize;
            mem_addr   <= src_ptr;
          end
        end
        ST_RD: begin
          mem_rd_req <= 1'b0;
          st         <= ST_CAP;
          if (abort_wr) abort_pend <= 1'b1;
        end
        ST_CAP: begin
          mem_wr_req <= 1'b1;
          mem_addr   <= dst_ptr;
          mem_wdata  <= ctl.wsize ? mem_rdata : {8'h00, mem_rdata[7:0]};
          st         <= ST_WR;
          if (abort_wr) abort_pend <= 1'b1;
        end
        default: begin
          mem_wr_req <= 1'b0;
          first_q    <= 1'b0;
          rem        <= rem_next;
          st         <= ST_IDLE;
          if (abort_now) begin
            armed      <= 1'b0;
            abort_pend <= 1'b0;
          end else if (wr_done) begin
            irq_done <= ctl.irq_en;
            if (rep_mode) begin
              rem     <= len;
              first_q <= 1'b1;
            end else begin
              armed <= 1'b0;
            end
          end else if (blk_mode) begin
            st         <= ST_RD;
            mem_rd_req <= 1'b1;
            mem_addr   <= src_ptr;
          end
        end
      endcase
    end
  end

  // R5: read and write never share a cycle
  p_bus_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  // R5: every write comes two cycles after its read
  p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> $past(mem_rd_req, 2));

  // R4: an idle channel that is not armed issues no read
  p_no_start_unarmed_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !armed) |=> !mem_rd_req);

  // R3: an abort write on an idle channel disarms it
  p_abort_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (abort_wr && st == ST_IDLE) |=> !armed);

  // R12: completion in a non-repeated mode leaves the channel disarmed
  p_done_disarm_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_done && !$past(ctl.tmode[1])) |-> !armed);
endmodule

// File: tb/test_dmach_top.sv
`timescale 1ns/1ps
module test_dmach_top;
  localparam int AW = 16;
  localparam int NT = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          arm_we = 1'b0;
  logic [7:0]    arm_wdata = '0;
  logic          man_req = 1'b0;
  logic [NT-1:0] trig_in = '0;
  logic          mem_rd_req, mem_wr_req, mem_word, armed, irq_done;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  logic [7:0]    mem [0:255];
  logic          pl_we = 1'b0;
  logic [7:0]    pl_addr = '0;
  logic [7:0]    pl_data = '0;
  int            wr_cnt = 0;
  int            irq_cnt = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  dmach_top #(.ADDR_W(AW), .NTRIG(NT)) i_dmach_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .arm_we(arm_we), .arm_wdata(arm_wdata), .man_req(man_req), .trig_in(trig_in),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .armed(armed), .irq_done(irq_done)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i);

  always @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
    if (mem_rd_req)
      mem_rdata <= mem_word ? {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                            : {8'h00, mem[mem_addr[7:0]]};
    if (mem_wr_req) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_word) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
      wr_cnt <= wr_cnt + 1;
    end
    if (irq_done) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(logic [7:0] a, logic [7:0] d);
    @(negedge clk); pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk); pl_we = 1'b0;
  endtask

  task automatic cfg(logic [1:0] s, logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic armw(logic [7:0] d);
    @(negedge clk); arm_we = 1'b1; arm_wdata = d;
    @(negedge clk); arm_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); man_req = 1'b1;
    @(negedge clk); man_req = 1'b0;
  endtask

  task automatic pulse_trig(int idx);
    @(negedge clk); trig_in[idx] = 1'b1;
    @(negedge clk); trig_in = '0;
  endtask

  function automatic logic [15:0] ctlw(bit ws, logic [1:0] tm, logic [4:0] ts,
                                       logic [1:0] si, logic [1:0] di, bit ie, bit c7);
    return {2'b00, c7, ie, di, si, ts, tm, ws};
  endfunction

  task automatic setup(logic [15:0] s, logic [15:0] d, logic [2:0] lm,
                       logic [12:0] ln, logic [15:0] c);
    cfg(2'd0, s); cfg(2'd1, d); cfg(2'd2, {lm, ln}); cfg(2'd3, c);
    armw(8'h01);
  endtask

  task automatic wait_irq(int limit, string req);
    int base = irq_cnt;
    int n = 0;
    while (irq_cnt == base && n < limit) begin @(negedge clk); n++; end
    check({req, " done pulse seen"}, 32'(irq_cnt != base), 32'd1);
  endtask

  task automatic t_reset();
    check("R1 armed", 32'(armed), 0);
    check("R1 rd", 32'(mem_rd_req), 0);
    check("R1 wr", 32'(mem_wr_req), 0);
    check("R1 irq", 32'(irq_done), 0);
  endtask

  task automatic t_timing();
    int w0;
    poke(8'h10, 8'hA5);
    setup(16'h0010, 16'h0080, 3'd0, 13'd1, ctlw(0, 2'd0, 5'd0, 2'd1, 2'd1, 1, 0));
    check("R3 armed after arm", 32'(armed), 1);
    @(negedge clk); man_req = 1'b1;
    @(negedge clk); man_req = 1'b0;
    check("R5 read issued", 32'(mem_rd_req), 1);
    check("R2 R5 read addr", 32'(mem_addr), 32'h10);
    cyc(2);
    check("R5 write issued", 32'(mem_wr_req), 1);
    check("R2 R5 write addr", 32'(mem_addr), 32'h80);
    check("R9 byte wdata", 32'(mem_wdata), 32'h00A5);
    cyc(1);
    check("R14 irq pulse", 32'(irq_done), 1);
    check("R12 disarm nonrepeat", 32'(armed), 0);
    cyc(1);
    check("R14 irq one cycle", 32'(irq_done), 0);
    check("R5 data copied", 32'(mem[8'h80]), 32'hA5);
    w0 = wr_cnt;
    pulse_req(); cyc(6);
    check("R4 unarmed ignores req", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_block();
    int w0 = wr_cnt;
    for (int i = 0; i < 4; i++) poke(8'(8'h20 + i), 8'(8'hC0 + i));
    setup(16'h0020, 16'h0090, 3'd0, 13'd4, ctlw(0, 2'd1, 5'd0, 2'd1, 2'd1, 1, 0));
    pulse_req(); wait_irq(100, "R11");
    check("R6 R11 block count", 32'(wr_cnt - w0), 4);
    for (int i = 0; i < 4; i++)
      check("R10 block data", 32'(mem[8'(8'h90 + i)]), 32'(8'hC0 + i));
  endtask

  task automatic t_single_trig();
    int w0;
    setup(16'h0020, 16'h00D0, 3'd0, 13'd3, ctlw(0, 2'd0, 5'd5, 2'd1, 2'd1, 1, 0));
    w0 = wr_cnt;
    pulse_trig(4); cyc(6);
    check("R4 wrong line ignored", 32'(wr_cnt - w0), 0);
    pulse_trig(5); cyc(6);
    check("R11 one unit per start", 32'(wr_cnt - w0), 1);
    check("R11 still armed", 32'(armed), 1);
    pulse_trig(5); cyc(6);
    pulse_trig(5); wait_irq(20, "R4");
    check("R6 single total", 32'(wr_cnt - w0), 3);
    setup(16'h0020, 16'h00D0, 3'd0, 13'd2, ctlw(0, 2'd0, 5'd0, 2'd1, 2'd1, 1, 0));
    w0 = wr_cnt;
    pulse_trig(0); pulse_trig(5); cyc(6);
    check("R4 select 0 ignores lines", 32'(wr_cnt - w0), 0);
    pulse_req(); cyc(6);
    check("R4 manual with select 0", 32'(wr_cnt - w0), 1);
    armw(8'h81);
  endtask

  task automatic t_var(logic [2:0] lm, bit c7, int exp, string req);
    int w0 = wr_cnt;
    setup(16'h0040, 16'h00F0, lm, 13'd0, ctlw(0, 2'd1, 5'd0, 2'd1, 2'd0, 1, c7));
    pulse_req(); wait_irq(1000, req);
    check(req, 32'(wr_cnt - w0), 32'(exp));
  endtask

  task automatic t_word();
    int w0 = wr_cnt;
    poke(8'h50, 8'h11); poke(8'h51, 8'h22); poke(8'h52, 8'h33); poke(8'h53, 8'h44);
    setup(16'h0050, 16'h00A0, 3'd0, 13'd2, ctlw(1, 2'd1, 5'd0, 2'd1, 2'd1, 1, 0));
    pulse_req(); wait_irq(100, "R9");
    check("R9 word count", 32'(wr_cnt - w0), 2);
    check("R9 word data", {mem[8'hA3], mem[8'hA2], mem[8'hA1], mem[8'hA0]}, 32'h44332211);
  endtask

  task automatic t_steps();
    poke(8'h60, 8'h61); poke(8'h62, 8'h62); poke(8'h64, 8'h63);
    setup(16'h0060, 16'h00B2, 3'd0, 13'd3, ctlw(0, 2'd1, 5'd0, 2'd2, 2'd3, 1, 0));
    pulse_req(); wait_irq(100, "R10");
    check("R10 step B2", 32'(mem[8'hB2]), 32'h61);
    check("R10 step B1", 32'(mem[8'hB1]), 32'h62);
    check("R10 step B0", 32'(mem[8'hB0]), 32'h63);
  endtask

  task automatic t_repeat();
    poke(8'h70, 8'h01); poke(8'h71, 8'h02);
    setup(16'h0070, 16'h00C0, 3'd0, 13'd2, ctlw(0, 2'd3, 5'd0, 2'd1, 2'd1, 1, 0));
    pulse_req(); wait_irq(100, "R12");
    check("R12 stays armed", 32'(armed), 1);
    check("R12 first pass", {mem[8'hC1], mem[8'hC0]}, 32'h0201);
    poke(8'h70, 8'h55); poke(8'h71, 8'h66);
    pulse_req(); wait_irq(100, "R12");
    check("R12 reloaded pointers", {mem[8'hC1], mem[8'hC0]}, 32'h6655);
    armw(8'h81);
    check("R3 abort idle", 32'(armed), 0);
  endtask

  task automatic t_arm_abort();
    int w0;
    setup(16'h0020, 16'h00E0, 3'd0, 13'd1, ctlw(0, 2'd0, 5'd0, 2'd1, 2'd1, 1, 0));
    armw(8'h81);
    check("R3 abort disarms", 32'(armed), 0);
    armw(8'h00);
    check("R3 bit0 clear no effect", 32'(armed), 0);
    w0 = wr_cnt;
    pulse_req(); cyc(6);
    check("R3 aborted channel idle", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_abort_mid();
    int w0, i0;
    setup(16'h0020, 16'h00E0, 3'd0, 13'd8, ctlw(0, 2'd1, 5'd0, 2'd1, 2'd1, 1, 0));
    w0 = wr_cnt; i0 = irq_cnt;
    pulse_req(); cyc(4);
    armw(8'h81); cyc(30);
    check("R13 no irq on abort", 32'(irq_cnt - i0), 0);
    check("R13 disarmed", 32'(armed), 0);
    check("R13 stopped early", 32'((wr_cnt - w0) >= 1 && (wr_cnt - w0) < 8), 1);
  endtask

  task automatic t_zero_noirq();
    int w0, i0;
    setup(16'h0020, 16'h00E0, 3'd0, 13'd0, ctlw(0, 2'd1, 5'd0, 2'd1, 2'd1, 1, 0));
    w0 = wr_cnt;
    @(negedge clk); man_req = 1'b1;
    @(negedge clk); man_req = 1'b0;
    check("R6 zero length irq", 32'(irq_done), 1);
    check("R6 zero length no read", 32'(mem_rd_req), 0);
    cyc(4);
    check("R6 zero length no write", 32'(wr_cnt - w0), 0);
    check("R6 zero length disarm", 32'(armed), 0);
    i0 = irq_cnt;
    setup(16'h0020, 16'h00E0, 3'd0, 13'd1, ctlw(0, 2'd1, 5'd0, 2'd1, 2'd1, 0, 0));
    pulse_req(); cyc(8);
    check("R14 disabled no irq", 32'(irq_cnt - i0), 0);
    check("R14 disabled still completes", 32'(armed), 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_timing();
    t_block();
    t_single_trig();
    poke(8'h40, 8'h03);
    t_var(3'd1, 0, 4, "R7 mode one-plus");
    t_var(3'd2, 0, 3, "R7 mode inclusive");
    t_var(3'd3, 0, 5, "R7 mode plus one");
    t_var(3'd4, 0, 6, "R7 mode plus two");
    poke(8'h40, 8'h83);
    t_var(3'd1, 1, 4, "R8 seven-bit count");
    t_var(3'd1, 0, 132, "R8 eight-bit count");
    t_word();
    t_steps();
    t_repeat();
    t_arm_abort();
    t_abort_mid();
    t_zero_noirq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule